// File: doc/BRIEF.md
# Fused multiply-add special-operand resolver

This block sits ahead of a double-precision fused multiply-add datapath that computes x*y+z. Each of the three 64-bit operands arrives together with a class code produced by an upstream classifier. Two variant flags negate the product or the addend, and a rounding-mode field is supplied as well. From the classes and signs alone, the block decides whether the result is already fixed by special operands: NaNs, infinities and zero products.

When the result is fixed, the block returns the 64-bit result and an invalid-operation flag. When it is not fixed, the block raises a proceed signal so that the arithmetic datapath takes over, and it passes along the effective product and addend signs.

The next state is formed in one combinational process and registered once, so every output follows its inputs by exactly one clock. The classification and the arithmetic are handled elsewhere.

Top module: `fma_special_resolver`

## Requirements
- R1: Every output is registered and reflects the inputs sampled at the previous rising clock edge. prod_sign equals x[63] XOR y[63] XOR neg_prod. add_sign equals z[63] XOR neg_add. Class codes are: 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signalling NaN.
- R2: NaN precedence is as follows. Any signalling NaN wins over any quiet NaN. Within each kind, z wins over x, and x wins over y.
- R3: When the chosen NaN is signalling, the result is that operand with fraction bit 51 set, and invalid is 1.
- R4: When the chosen NaN is quiet, the result is that operand's bits unchanged, and invalid is 0.
- R5: An infinity multiplied by a zero, in either order, gives the default NaN 0x7FF8000000000000 with invalid set. This holds whatever z is, as long as z is not a NaN.
- R6: An infinite product whose addend z is infinite with add_sign different from prod_sign gives the default NaN with invalid set.
- R7: Any other infinite product gives infinity with sign prod_sign, that is {prod_sign, 11'h7FF, 52'h0}, with invalid 0.
- R8: A finite, nonzero product with an infinite z gives infinity with sign add_sign.
- R9: A zero product and a zero z with add_sign equal to prod_sign return z's raw input bits.
- R10: A zero product and a zero z with add_sign different from prod_sign return a zero. That zero is negative only when round_mode is 3 (toward minus infinity); modes 0 to 2 give +0.
- R11: A zero product and a finite, nonzero z return z's raw input bits, even when neg_add is set. An infinite z with a zero product gives infinity with sign add_sign.
- R12: resolved is 1 exactly when one of the cases above applies. Otherwise proceed is 1, res_bits is 0 and invalid is 0. proceed and resolved are never 1 together.
- R13: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| z_bits | input | 64 | Addend operand |
| x_bits | input | 64 | First multiplicand |
| y_bits | input | 64 | Second multiplicand |
| z_cls | input | 3 | Class code of z |
| x_cls | input | 3 | Class code of x |
| y_cls | input | 3 | Class code of y |
| neg_prod | input | 1 | Invert the product sign |
| neg_add | input | 1 | Invert the addend sign |
| round_mode | input | 2 | Rounding mode; 3 means toward minus infinity |
| res_bits | output | 64 | Resolved result |
| resolved | output | 1 | Result fixed by special operands |
| invalid | output | 1 | Invalid-operation flag |
| proceed | output | 1 | Hand off to the arithmetic datapath |
| prod_sign | output | 1 | Effective product sign |
| add_sign | output | 1 | Effective addend sign |

## Verification
The assertions assume that each class code agrees with its operand's bits. In particular, a signalling NaN has an all-ones exponent and fraction bit 51 clear, and no code above 5 ever appears. The stimulus uses only a fixed set of operand constants whose bits match their class codes. It holds the inputs stable across each rising edge by changing them only on falling edges. Each vector is chosen to land in one resolution branch, with the flags and rounding mode set so that the sign choices are told apart.

// File: rtl/fma_spec_pkg.sv
package fma_spec_pkg;
    localparam int EXP_W     = 11;
    localparam int FRAC_W    = 52;
    localparam int FP_W      = 1 + EXP_W + FRAC_W;
    localparam int QUIET_BIT = FRAC_W - 1;
    localparam int CLS_W     = 3;
    localparam int RM_W      = 2;
    localparam int N_OPS     = 3;

    localparam logic [CLS_W-1:0] CLS_ZERO  = 3'd0;
    localparam logic [CLS_W-1:0] CLS_DNORM = 3'd1;
    localparam logic [CLS_W-1:0] CLS_NORM  = 3'd2;
    localparam logic [CLS_W-1:0] CLS_INF   = 3'd3;
    localparam logic [CLS_W-1:0] CLS_QNAN  = 3'd4;
    localparam logic [CLS_W-1:0] CLS_SNAN  = 3'd5;

    localparam logic [RM_W-1:0] RM_TO_NEG = 2'd3;

    typedef struct packed {
        logic            resolved;
        logic            invalid;
        logic            proceed;
        logic            prod_sign;
        logic            add_sign;
        logic [FP_W-1:0] value;
    } resolver_state_t;

    function automatic logic [FP_W-1:0] fp_inf(input logic sign);
        return {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    function automatic logic [FP_W-1:0] fp_zero(input logic sign);
        return {sign, {(FP_W-1){1'b0}}};
    endfunction

    function automatic logic [FP_W-1:0] fp_default_nan();
        return {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    endfunction
endpackage

// File: rtl/fma_sign_adjust.sv
module fma_sign_adjust (
    input  logic x_sign,
    input  logic y_sign,
    input  logic z_sign,
    input  logic neg_prod,
    input  logic neg_add,
    output logic prod_sign,
    output logic add_sign
);
    always_comb begin
        prod_sign = x_sign ^ y_sign ^ neg_prod;
        add_sign  = z_sign ^ neg_add;
    end
endmodule

// File: rtl/fma_nan_pick.sv
module fma_nan_pick
    import fma_spec_pkg::*;
#(
    parameter int NUM_OPS = N_OPS,
    parameter int OP_W    = FP_W,
    parameter int QB      = QUIET_BIT
) (
    input  logic [NUM_OPS-1:0][OP_W-1:0]  ops,   // index 0 has highest priority
    input  logic [NUM_OPS-1:0][CLS_W-1:0] cls,
    output logic                          hit,
    output logic                          invalid,
    output logic [OP_W-1:0]               value
);
    logic [NUM_OPS-1:0] is_snan;
    logic [NUM_OPS-1:0] is_qnan;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
        assign is_snan[g] = (cls[g] == CLS_SNAN);
        assign is_qnan[g] = (cls[g] == CLS_QNAN);
    end

    always_comb begin
        hit     = 1'b0;
        invalid = 1'b0;
        value   = '0;
        // quiet group first, lower index overrides higher
        for (int i = NUM_OPS - 1; i >= 0; i--) begin
            if (is_qnan[i]) begin
                hit   = 1'b1;
                value = ops[i];
            end
        end
        // signalling group overrides every quiet NaN
        for (int i = NUM_OPS - 1; i >= 0; i--) begin
            if (is_snan[i]) begin
                hit       = 1'b1;
                invalid   = 1'b1;
                value     = ops[i];
                value[QB] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fma_inf_zero_resolve.sv
module fma_inf_zero_resolve
    import fma_spec_pkg::*;
(
    input  logic [CLS_W-1:0] x_cls,
    input  logic [CLS_W-1:0] y_cls,
    input  logic [CLS_W-1:0] z_cls,
    input  logic [FP_W-1:0]  z_bits,
    input  logic             prod_sign,
    input  logic             add_sign,
    input  logic [RM_W-1:0]  round_mode,
    output logic             hit,
    output logic             invalid,
    output logic [FP_W-1:0]  value
);
    logic prod_inf, prod_zero, z_inf, z_zero;

    always_comb begin
        prod_inf  = (x_cls == CLS_INF)  || (y_cls == CLS_INF);
        prod_zero = (x_cls == CLS_ZERO) || (y_cls == CLS_ZERO);
        z_inf     = (z_cls == CLS_INF);
        z_zero    = (z_cls == CLS_ZERO);

        hit     = 1'b1;
        invalid = 1'b0;
        value   = '0;
        if (prod_inf && prod_zero) begin
            invalid = 1'b1;
            value   = fp_default_nan();
        end else if (prod_inf) begin
            if (z_inf && (add_sign != prod_sign)) begin
                invalid = 1'b1;
                value   = fp_default_nan();
            end else begin
                value = fp_inf(prod_sign);
            end
        end else if (prod_zero) begin
            if (z_inf) begin
                value = fp_inf(add_sign);
            end else if (z_zero && (add_sign != prod_sign)) begin
                value = fp_zero(round_mode == RM_TO_NEG);
            end else begin
                value = z_bits;
            end
        end else if (z_inf) begin
            value = fp_inf(add_sign);
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
    import fma_spec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FP_W-1:0]  z_bits,
    input  logic [FP_W-1:0]  x_bits,
    input  logic [FP_W-1:0]  y_bits,
    input  logic [CLS_W-1:0] z_cls,
    input  logic [CLS_W-1:0] x_cls,
    input  logic [CLS_W-1:0] y_cls,
    input  logic             neg_prod,
    input  logic             neg_add,
    input  logic [RM_W-1:0]  round_mode,
    output logic [FP_W-1:0]  res_bits,
    output logic             resolved,
    output logic             invalid,
    output logic             proceed,
    output logic             prod_sign,
    output logic             add_sign
);
    logic            ps_c, as_c;
    logic            nan_hit, nan_inv;
    logic [FP_W-1:0] nan_val;
    logic            iz_hit, iz_inv;
    logic [FP_W-1:0] iz_val;
    resolver_state_t st_d, st_q;
    logic            started_q;

    fma_sign_adjust u_sign (
        .x_sign    (x_bits[FP_W-1]),
        .y_sign    (y_bits[FP_W-1]),
        .z_sign    (z_bits[FP_W-1]),
        .neg_prod  (neg_prod),
        .neg_add   (neg_add),
        .prod_sign (ps_c),
        .add_sign  (as_c)
    );

    fma_nan_pick #(.NUM_OPS(N_OPS), .OP_W(FP_W), .QB(QUIET_BIT)) u_nan (
        .ops     ({y_bits, x_bits, z_bits}),
        .cls     ({y_cls, x_cls, z_cls}),
        .hit     (nan_hit),
        .invalid (nan_inv),
        .value   (nan_val)
    );

    fma_inf_zero_resolve u_iz (
        .x_cls      (x_cls),
        .y_cls      (y_cls),
        .z_cls      (z_cls),
        .z_bits     (z_bits),
        .prod_sign  (ps_c),
        .add_sign   (as_c),
        .round_mode (round_mode),
        .hit        (iz_hit),
        .invalid    (iz_inv),
        .value      (iz_val)
    );

    always_comb begin
        st_d           = '0;
        st_d.prod_sign = ps_c;
        st_d.add_sign  = as_c;
        if (nan_hit) begin
            st_d.resolved = 1'b1;
            st_d.invalid  = nan_inv;
            st_d.value    = nan_val;
        end else if (iz_hit) begin
            st_d.resolved = 1'b1;
            st_d.invalid  = iz_inv;
            st_d.value    = iz_val;
        end else begin
            st_d.proceed  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            started_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            started_q <= 1'b1;
        end
    end

    assign res_bits  = st_q.value;
    assign resolved  = st_q.resolved;
    assign invalid   = st_q.invalid;
    assign proceed   = st_q.proceed;
    assign prod_sign = st_q.prod_sign;
    assign add_sign  = st_q.add_sign;

    // helper terms over the raw inputs, for the checks below
    logic any_snan_c, any_nan_c, z_inf_in_c, p_zero_in_c, p_inf_in_c;
    always_comb begin
        any_snan_c  = (x_cls == CLS_SNAN) || (y_cls == CLS_SNAN) || (z_cls == CLS_SNAN);
        any_nan_c   = any_snan_c || (x_cls == CLS_QNAN) || (y_cls == CLS_QNAN)
                      || (z_cls == CLS_QNAN);
        z_inf_in_c  = (z_cls == CLS_INF);
        p_zero_in_c = (x_cls == CLS_ZERO) || (y_cls == CLS_ZERO);
        p_inf_in_c  = (x_cls == CLS_INF) || (y_cls == CLS_INF);
    end

    // R12: handoff and resolution exclusive
    a_r12_proceed_excl: assert property (@(posedge clk) disable iff (!rst_n)
        proceed |-> (!resolved && !invalid && res_bits == '0));

    // R1: registered effective signs
    a_r1_sign_follow: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (prod_sign == $past(x_bits[FP_W-1] ^ y_bits[FP_W-1] ^ neg_prod)
                       && add_sign == $past(z_bits[FP_W-1] ^ neg_add)));

    // R3: any signalling NaN raises invalid and yields a quiet pattern
    a_r3_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(any_snan_c)) |-> (invalid && resolved && res_bits[QUIET_BIT]));

    // R6: opposite infinities are invalid
    a_r6_inf_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(!any_nan_c && p_inf_in_c && !p_zero_in_c && z_inf_in_c
                            && (x_bits[FP_W-1] ^ y_bits[FP_W-1] ^ neg_prod)
                               != (z_bits[FP_W-1] ^ neg_add)))
        |-> (invalid && res_bits == fp_default_nan()));

    // R8: finite nonzero product with infinite addend
    a_r8_addend_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(!any_nan_c && !p_inf_in_c && !p_zero_in_c && z_inf_in_c))
        |-> (!invalid && res_bits == fp_inf(add_sign)));

    // R13: reset clears outputs
    a_r13_reset_clear: assert property (@(posedge clk)
        (!rst_n && started_q) |=> (!resolved && !proceed && res_bits == '0));
endmodule

// File: tb/fma_special_resolver_bench.sv
module fma_special_resolver_bench;
    import fma_spec_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic [FP_W-1:0]  z_bits, x_bits, y_bits;
    logic [CLS_W-1:0] z_cls, x_cls, y_cls;
    logic             neg_prod, neg_add;
    logic [RM_W-1:0]  round_mode;
    logic [FP_W-1:0]  res_bits;
    logic             resolved, invalid, proceed, prod_sign, add_sign;

    fma_special_resolver u_fma_special_resolver (
        .clk(clk), .rst_n(rst_n), .z_bits(z_bits), .x_bits(x_bits), .y_bits(y_bits),
        .z_cls(z_cls), .x_cls(x_cls), .y_cls(y_cls), .neg_prod(neg_prod),
        .neg_add(neg_add), .round_mode(round_mode), .res_bits(res_bits),
        .resolved(resolved), .invalid(invalid), .proceed(proceed),
        .prod_sign(prod_sign), .add_sign(add_sign)
    );

    localparam logic [63:0] P1   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] N2   = 64'hC000_0000_0000_0000;
    localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QN1  = 64'h7FF8_0000_0000_0002;
    localparam logic [63:0] QN2  = 64'hFFF8_0000_0000_0003;
    localparam logic [63:0] SN1  = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] SN2  = 64'hFFF4_0000_0000_0000;
    localparam logic [63:0] DN   = 64'h0000_0000_0000_0001;
    localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;

    typedef struct {
        logic [63:0] res;
        logic        rsv, inv, prc, ps, as_;
        int          due;
        string       tag;
    } item_t;

    item_t q[$];
    int cyc = 0, total = 0, bad = 0;
    bit done = 0;

    // expected behaviour, derived from the requirement list
    function automatic item_t predict(input logic [63:0] zb, xb, yb,
                                      input logic [2:0] zc, xc, yc,
                                      input logic np, na, input logic [1:0] rm);
        item_t e;
        logic [63:0] ob [3];
        logic [2:0]  oc [3];
        logic pi, pz;
        ob[0] = zb; ob[1] = xb; ob[2] = yb;
        oc[0] = zc; oc[1] = xc; oc[2] = yc;
        e.ps = xb[63] ^ yb[63] ^ np;
        e.as_ = zb[63] ^ na;
        e.res = '0; e.rsv = 1; e.inv = 0; e.prc = 0;
        for (int k = 0; k < 3; k++) begin
            if (oc[k] == 3'd5) begin
                e.res = ob[k] | 64'h0008_0000_0000_0000; e.inv = 1; return e;
            end
        end
        for (int k = 0; k < 3; k++) begin
            if (oc[k] == 3'd4) begin
                e.res = ob[k]; return e;
            end
        end
        pi = (xc == 3'd3) || (yc == 3'd3);
        pz = (xc == 3'd0) || (yc == 3'd0);
        if (pi && pz) begin
            e.res = DNAN; e.inv = 1;
        end else if (pi) begin
            if (zc == 3'd3 && e.as_ != e.ps) begin
                e.res = DNAN; e.inv = 1;
            end else e.res = {e.ps, 63'h7FF0_0000_0000_0000};
        end else if (pz) begin
            if (zc == 3'd3) e.res = {e.as_, 63'h7FF0_0000_0000_0000};
            else if (zc == 3'd0 && e.as_ != e.ps) e.res = {(rm == 2'd3), 63'h0};
            else e.res = zb;
        end else if (zc == 3'd3) begin
            e.res = {e.as_, 63'h7FF0_0000_0000_0000};
        end else begin
            e.rsv = 0; e.prc = 1;
        end
        return e;
    endfunction

    task automatic drive(input string tag, input logic [63:0] zb, xb, yb,
                         input logic [2:0] zc, xc, yc,
                         input logic np, na, input logic [1:0] rm);
        item_t e;
        @(negedge clk);
        z_bits = zb; x_bits = xb; y_bits = yb;
        z_cls = zc; x_cls = xc; y_cls = yc;
        neg_prod = np; neg_add = na; round_mode = rm;
        e = predict(zb, xb, yb, zc, xc, yc, np, na, rm);
        e.due = cyc + 1;
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compare one cycle after each item was driven
    always @(posedge clk) begin
        cyc = cyc + 1;
        #2;
        if (q.size() > 0 && q[0].due <= cyc) begin
            item_t e;
            e = q.pop_front();
            total++;
            if (res_bits !== e.res || resolved !== e.rsv || invalid !== e.inv ||
                proceed !== e.prc || prod_sign !== e.ps || add_sign !== e.as_) begin
                bad++;
                $display("FAIL %s: got res=%h rsv=%b inv=%b prc=%b ps=%b as=%b exp res=%h rsv=%b inv=%b prc=%b ps=%b as=%b",
                         e.tag, res_bits, resolved, invalid, proceed, prod_sign, add_sign,
                         e.res, e.rsv, e.inv, e.prc, e.ps, e.as_);
            end
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout exp completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 0;
        z_bits = SN1; x_bits = SN1; y_bits = SN1;
        z_cls = 3'd5; x_cls = 3'd5; y_cls = 3'd5;
        neg_prod = 1; neg_add = 1; round_mode = 2'd3;
        repeat (3) @(negedge clk);
        total++;
        if (res_bits !== '0 || resolved || invalid || proceed || prod_sign || add_sign) begin
            bad++;
            $display("FAIL R13: got res=%h rsv=%b prc=%b exp all zero", res_bits, resolved, proceed);
        end
        rst_n = 1;

        drive("R1 R12 normal add",   P1, P1, N2, 3'd2, 3'd2, 3'd2, 0, 0, 2'd0);
        drive("R1 negate product",   N2, P1, N2, 3'd2, 3'd2, 3'd2, 1, 0, 2'd0);
        drive("R1 negate both",      N2, N2, N2, 3'd2, 3'd2, 3'd2, 1, 1, 2'd0);
        drive("R2 snan y over qnan z", QN1, P1, SN1, 3'd4, 3'd2, 3'd5, 0, 0, 2'd0);
        drive("R2 snan x over snan y", P1, SN2, SN1, 3'd2, 3'd5, 3'd5, 0, 0, 2'd0);
        drive("R2 qnan x over qnan y", P1, QN2, QN1, 3'd2, 3'd4, 3'd4, 0, 0, 2'd0);
        drive("R3 snan z",           SN2, QN1, P1, 3'd5, 3'd4, 3'd2, 0, 0, 2'd0);
        drive("R4 qnan z",           QN2, PINF, PZ, 3'd4, 3'd3, 3'd0, 0, 0, 2'd0);
        drive("R5 inf times zero",   NINF, PINF, PZ, 3'd3, 3'd3, 3'd0, 0, 0, 2'd0);
        drive("R5 zero times inf",   P1, NZ, NINF, 3'd2, 3'd0, 3'd3, 0, 0, 2'd0);
        drive("R6 opposite inf",     NINF, PINF, P1, 3'd3, 3'd3, 3'd2, 0, 0, 2'd0);
        drive("R7 same inf via neg_add", NINF, PINF, P1, 3'd3, 3'd3, 3'd2, 0, 1, 2'd0);
        drive("R7 inf times subnormal", P1, DN, PINF, 3'd2, 3'd1, 3'd3, 1, 0, 2'd0);
        drive("R8 finite prod inf z", PINF, P1, DN, 3'd3, 3'd2, 3'd1, 0, 1, 2'd0);
        drive("R9 zero prod zero z same", NZ, NZ, P1, 3'd0, 3'd0, 3'd2, 0, 0, 2'd3);
        drive("R10 opposite zeros nearest", NZ, PZ, P1, 3'd0, 3'd0, 3'd2, 0, 0, 2'd0);
        drive("R10 opposite zeros down", PZ, NZ, P1, 3'd0, 3'd0, 3'd2, 0, 0, 2'd3);
        drive("R11 zero prod finite z", N2, PZ, P1, 3'd2, 3'd0, 3'd2, 0, 0, 2'd0);
        drive("R11 raw z under neg_add", DN, P1, PZ, 3'd1, 3'd2, 3'd0, 0, 1, 2'd0);
        drive("R11 zero prod inf z", NINF, PZ, N2, 3'd3, 3'd0, 3'd2, 0, 1, 2'd0);
        drive("R12 zero addend proceeds", PZ, P1, N2, 3'd0, 3'd2, 3'd2, 0, 0, 2'd0);
        drive("R12 subnormals proceed", DN, DN, DN, 3'd1, 3'd1, 3'd1, 0, 0, 2'd3);

        repeat (4) @(negedge clk);
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R1: got %0d pending results exp 0", q.size());
        end
        done = 1;
        finish_run();
    end
endmodule